// File: doc/BRIEF.md
# Buffered PWM / Interval Timer

This block is an 8-bit up-counter with two modes of operation. In pulse-width mode it produces a repeating waveform on one output pin. Each period is 256 count strobes long. The pin is high for a number of strobes equal to a duty value that software writes. That duty value is held in a shadow latch that reloads only when the counter wraps to zero. A write therefore never changes the waveform part way through a period. In interval mode the counter runs up to the duty/compare value, then clears, raises a request flag and can drive an interrupt line.

The count rate comes from one of four externally generated enable strobes. A 2-bit select field picks which one. The block has no clock divider of its own. Software reaches the block through a small synchronous register port with a write strobe, a 2-bit address and a combinational read path.

A two-state machine governs the mode. The states are `ST_TIMER` (interval counting) and `ST_PWM` (waveform generation). Transition `GO_PWM` fires when the mode bit is 1 while in `ST_TIMER`. Transition `GO_TIMER` fires when the mode bit is 0 while in `ST_PWM`. Both transitions clear the counter. `GO_PWM` also loads the latch from the compare register.

Top module: `pwm_tmr`

## Requirements
- R1: A synchronous active-high reset clears the control register, the compare register, the counter and the latch to zero. It also drives the output pin and the interrupt line low.
- R2: Register map.
    - Address 0 is control: bit 0 selects waveform mode, bits 2:1 select the strobe source, bit 3 is the request flag and bit 4 is the interrupt enable. It reads back in the same layout, with upper bits 0.
    - Address 1 is the compare register.
    - Address 2 reads the counter.
    - Address 3 reads the active latch.
    - Addresses 2 and 3 ignore writes.
- R3: On the clock edge that follows the mode bit becoming 1, the block enters `ST_PWM`, the counter becomes 0 and the latch takes the compare register value.
- R4: The counter advances by one only on cycles where the strobe chosen by the select field is high. The other three strobes have no effect. In waveform mode it wraps from 255 to 0, so a period lasts 256 strobes.
- R5: In waveform mode the pin is high exactly while the counter is below the latch. Over one period it is high for latch-value strobes: 0 gives never high, 0x80 gives 128 and 0xFF gives 255.
- R6: In waveform mode the latch reloads from the compare register only as the counter wraps to 0. A compare write during a period first shapes the next period.
- R7: One clock after the mode bit is cleared, the block is in `ST_TIMER`, the pin is low and the counter is 0.
- R8: In interval mode, a selected strobe that arrives while the counter equals the compare register clears the counter and sets the request flag.
- R9: In interval mode the interrupt line is the AND of the request flag and the enable bit. Writing 0 to the flag clears it. Writing 1 leaves it unchanged. A simultaneous match wins over a clear.
- R10: In waveform mode the interrupt line stays low whatever the flag and enable hold, and the flag is never set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Combinational read data for addr_i |
| tick_i | input | 4 | Four count-enable strobes, one per source |
| pwm_o | output | 1 | Waveform output pin |
| irq_o | output | 1 | Interrupt request line |

## Verification
A latch that reloaded at the wrong moment would show up in the first period after a mid-period compare write. The pin would then stay high for a count other than the old duty, and the latch readback would change before the wrap. A counter that stepped on an unselected strobe, or failed to wrap at 256, would show up within one period. The count of high samples and the counter readback after exactly 256 strobes would both be off. A mode machine stuck in the wrong state shows one clock after a mode write: the pin stays high, the counter is not cleared, or the interrupt line is not suppressed.

// File: rtl/pwm_tmr_pkg.sv
package pwm_tmr_pkg;

    typedef enum logic {
        ST_TIMER = 1'b0,
        ST_PWM   = 1'b1
    } tmr_state_e;

    localparam int CTRL_MODE_BIT = 0;
    localparam int CTRL_SEL_LSB  = 1;

endpackage

// File: rtl/pwm_tmr_tick_sel.sv
module pwm_tmr_tick_sel #(
    parameter int N_SRC = 4,
    parameter int SEL_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic [N_SRC-1:0] tick_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             tick_o
);

    logic [N_SRC-1:0] hit;

    for (genvar s = 0; s < N_SRC; s++) begin : g_src
        assign hit[s] = tick_i[s] && (sel_i == SEL_W'(s));
    end

    assign tick_o = |hit;

endmodule

// File: rtl/pwm_tmr_regs.sv
module pwm_tmr_regs #(
    parameter int CNT_W = 8,
    parameter int SEL_W = 2
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             wr_en_i,
    input  logic [1:0]       addr_i,
    input  logic [CNT_W-1:0] wdata_i,
    input  logic             match_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [CNT_W-1:0] latch_i,
    output logic [CNT_W-1:0] rdata_o,
    output logic             mode_o,
    output logic [SEL_W-1:0] sel_o,
    output logic             flag_o,
    output logic             en_o,
    output logic [CNT_W-1:0] cmp_o
);
    import pwm_tmr_pkg::*;

    localparam int FLAG_BIT = CTRL_SEL_LSB + SEL_W;
    localparam int EN_BIT   = FLAG_BIT + 1;
    localparam int PAD_W    = CNT_W - EN_BIT - 1;

    localparam logic [1:0] A_CTRL  = 2'd0;
    localparam logic [1:0] A_CMP   = 2'd1;
    localparam logic [1:0] A_CNT   = 2'd2;
    localparam logic [1:0] A_LATCH = 2'd3;

    logic wr_ctrl;
    logic wr_cmp;

    assign wr_ctrl = wr_en_i && (addr_i == A_CTRL);
    assign wr_cmp  = wr_en_i && (addr_i == A_CMP);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            mode_o <= 1'b0;
            sel_o  <= '0;
            en_o   <= 1'b0;
            flag_o <= 1'b0;
            cmp_o  <= '0;
        end else begin
            if (wr_ctrl) begin
                mode_o <= wdata_i[CTRL_MODE_BIT];
                sel_o  <= wdata_i[CTRL_SEL_LSB +: SEL_W];
                en_o   <= wdata_i[EN_BIT];
                flag_o <= (flag_o && wdata_i[FLAG_BIT]) || match_i;
            end else begin
                flag_o <= flag_o || match_i;
            end
            if (wr_cmp) begin
                cmp_o <= wdata_i;
            end
        end
    end

    always_comb begin
        unique case (addr_i)
            A_CTRL:  rdata_o = {{PAD_W{1'b0}}, en_o, flag_o, sel_o, mode_o};
            A_CMP:   rdata_o = cmp_o;
            A_CNT:   rdata_o = cnt_i;
            A_LATCH: rdata_o = latch_i;
            default: rdata_o = '0;
        endcase
    end

endmodule

// File: rtl/pwm_tmr_core.sv
module pwm_tmr_core #(
    parameter int CNT_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             mode_i,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] cmp_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] latch_o,
    output logic             match_o,
    output logic             in_pwm_o,
    output logic             pwm_o
);
    import pwm_tmr_pkg::*;

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    tmr_state_e state_q;
    tmr_state_e state_d;
    logic       switching;

    // next-state logic: GO_PWM / GO_TIMER
    always_comb begin
        unique case (state_q)
            ST_TIMER: state_d = mode_i ? ST_PWM : ST_TIMER;
            ST_PWM:   state_d = mode_i ? ST_PWM : ST_TIMER;
            default:  state_d = ST_TIMER;
        endcase
    end

    assign switching = (state_d != state_q);

    // state register
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= ST_TIMER;
        end else begin
            state_q <= state_d;
        end
    end

    // counter and shadow latch
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt_o   <= '0;
            latch_o <= '0;
        end else if (switching) begin
            cnt_o <= '0;
            if (state_d == ST_PWM) begin
                latch_o <= cmp_i;
            end
        end else if (tick_i) begin
            unique case (state_q)
                ST_PWM: begin
                    cnt_o <= cnt_o + 1'b1;
                    if (cnt_o == CNT_MAX) begin
                        latch_o <= cmp_i;
                    end
                end
                ST_TIMER: begin
                    if (cnt_o == cmp_i) begin
                        cnt_o <= '0;
                    end else begin
                        cnt_o <= cnt_o + 1'b1;
                    end
                end
                default: cnt_o <= '0;
            endcase
        end
    end

    // outputs
    always_comb begin
        in_pwm_o = 1'b0;
        pwm_o    = 1'b0;
        match_o  = 1'b0;
        unique case (state_q)
            ST_PWM: begin
                in_pwm_o = 1'b1;
                pwm_o    = (cnt_o < latch_o);
            end
            ST_TIMER: begin
                match_o = tick_i && !switching && (cnt_o == cmp_i);
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/pwm_tmr.sv
module pwm_tmr #(
    parameter int CNT_W = 8,
    parameter int N_SRC = 4
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             wr_en_i,
    input  logic [1:0]       addr_i,
    input  logic [CNT_W-1:0] wdata_i,
    output logic [CNT_W-1:0] rdata_o,
    input  logic [N_SRC-1:0] tick_i,
    output logic             pwm_o,
    output logic             irq_o
);

    localparam int SEL_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;

    logic             mode_bit;
    logic [SEL_W-1:0] sel;
    logic             flag;
    logic             irq_en;
    logic [CNT_W-1:0] cmp;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] latch;
    logic             match;
    logic             in_pwm;
    logic             sel_tick;

    pwm_tmr_tick_sel #(.N_SRC(N_SRC), .SEL_W(SEL_W)) u_sel (
        .tick_i (tick_i),
        .sel_i  (sel),
        .tick_o (sel_tick)
    );

    pwm_tmr_regs #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_regs (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .wr_en_i (wr_en_i),
        .addr_i  (addr_i),
        .wdata_i (wdata_i),
        .match_i (match),
        .cnt_i   (cnt),
        .latch_i (latch),
        .rdata_o (rdata_o),
        .mode_o  (mode_bit),
        .sel_o   (sel),
        .flag_o  (flag),
        .en_o    (irq_en),
        .cmp_o   (cmp)
    );

    pwm_tmr_core #(.CNT_W(CNT_W)) u_core (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .mode_i   (mode_bit),
        .tick_i   (sel_tick),
        .cmp_i    (cmp),
        .cnt_o    (cnt),
        .latch_o  (latch),
        .match_o  (match),
        .in_pwm_o (in_pwm),
        .pwm_o    (pwm_o)
    );

    assign irq_o = flag && irq_en && !in_pwm;

endmodule

// File: rtl/pwm_tmr_chk.sv
module pwm_tmr_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk_i,
    input logic             rst_i,
    input logic             pwm_o,
    input logic             irq_o,
    input logic             in_pwm,
    input logic             mode_bit,
    input logic             sel_tick,
    input logic             flag,
    input logic             irq_en,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] latch
);

    AST_ENTRY_CLEARS: assert property (@(posedge clk_i) disable iff (rst_i)
        (!in_pwm && mode_bit) |=> (in_pwm && cnt == '0)); // R3

    AST_CNT_HOLDS: assert property (@(posedge clk_i) disable iff (rst_i)
        (in_pwm && mode_bit && !sel_tick) |=> $stable(cnt)); // R4

    AST_ZERO_DUTY: assert property (@(posedge clk_i) disable iff (rst_i)
        (in_pwm && latch == '0) |-> !pwm_o); // R5

    AST_HIGH_AT_WRAP: assert property (@(posedge clk_i) disable iff (rst_i)
        (in_pwm && cnt == '0 && latch != '0) |-> pwm_o); // R5

    AST_LATCH_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
        (in_pwm && $past(in_pwm) && cnt != '0) |-> $stable(latch)); // R6

    AST_LOW_IN_TIMER: assert property (@(posedge clk_i) disable iff (rst_i)
        !in_pwm |-> !pwm_o); // R7

    AST_IRQ_NEEDS_EN: assert property (@(posedge clk_i) disable iff (rst_i)
        irq_o |-> (flag && irq_en)); // R9

    AST_NO_IRQ_PWM: assert property (@(posedge clk_i) disable iff (rst_i)
        in_pwm |-> !irq_o); // R10

    AST_NO_FLAG_PWM: assert property (@(posedge clk_i) disable iff (rst_i)
        (in_pwm && mode_bit && !flag) |=> !flag); // R10

endmodule

bind pwm_tmr pwm_tmr_chk #(.CNT_W(CNT_W)) u_chk (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .pwm_o    (pwm_o),
    .irq_o    (irq_o),
    .in_pwm   (in_pwm),
    .mode_bit (mode_bit),
    .sel_tick (sel_tick),
    .flag     (flag),
    .irq_en   (irq_en),
    .cnt      (cnt),
    .latch    (latch)
);

// File: tb/pwm_tmr_tb_top.sv
`timescale 1ns/1ps
module pwm_tmr_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic [3:0] tick = 4'b0000;
    logic       pwm;
    logic       irq;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // stimulus: {compare value, expected high strobes per period}
    localparam logic [15:0] DUTY_V [5] = '{
        {8'h00, 8'd0}, {8'h01, 8'd1}, {8'h40, 8'd64},
        {8'h80, 8'd128}, {8'hFF, 8'd255}
    };

    always #2.5 clk = ~clk;

    pwm_tmr dut_i (
        .clk_i   (clk),
        .rst_i   (rst),
        .wr_en_i (wr_en),
        .addr_i  (addr),
        .wdata_i (wdata),
        .rdata_o (rdata),
        .tick_i  (tick),
        .pwm_o   (pwm),
        .irq_o   (irq)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output int v);
        addr = a;
        #0.5;
        v = int'(rdata);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        int v;
        int highs;
        int highs2;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state, R2 map readback
        rd(2'd0, v); check("R1 ctrl", v, 0);
        rd(2'd1, v); check("R1 cmp", v, 0);
        rd(2'd2, v); check("R1 cnt", v, 0);
        rd(2'd3, v); check("R1 latch", v, 0);
        check("R1 pwm", int'(pwm), 0);
        check("R1 irq", int'(irq), 0);
        wr(2'd1, 8'h5A);
        rd(2'd1, v); check("R2 cmp readback", v, 8'h5A);
        wr(2'd3, 8'h77);
        rd(2'd3, v); check("R2 latch ignores write", v, 0);

        // table walk: R3 R4 R5 R7
        foreach (DUTY_V[i]) begin
            tick = 4'b0000;
            wr(2'd1, DUTY_V[i][15:8]);
            wr(2'd0, 8'h01);
            @(negedge clk);
            rd(2'd3, v); check("R3 latch on entry", v, int'(DUTY_V[i][15:8]));
            rd(2'd2, v); check("R3 cnt on entry", v, 0);
            tick = 4'b0001;
            highs = 0;
            for (int j = 0; j < 256; j++) begin
                if (pwm) highs++;
                @(negedge clk);
            end
            tick = 4'b0000;
            check("R5 high count", highs, int'(DUTY_V[i][7:0]));
            rd(2'd2, v); check("R4 wrap after 256", v, 0);
            wr(2'd0, 8'h00);
            @(negedge clk);
            check("R7 pin low on exit", int'(pwm), 0);
            rd(2'd2, v); check("R7 cnt cleared", v, 0);
        end

        // R6: mid-period compare write
        wr(2'd1, 8'h10);
        wr(2'd0, 8'h01);
        @(negedge clk);
        tick = 4'b0001;
        highs = 0; highs2 = 0;
        for (int j = 0; j < 512; j++) begin
            if (pwm) begin
                if (j < 256) highs++; else highs2++;
            end
            if (j == 100) begin
                wr_en = 1'b1; addr = 2'd1; wdata = 8'hC0;
            end else if (j == 101) begin
                wr_en = 1'b0;
            end else if (j == 200) begin
                rd(2'd3, v); check("R6 latch held mid-period", v, 8'h10);
            end
            @(negedge clk);
        end
        tick = 4'b0000;
        check("R6 old duty in current period", highs, 16);
        check("R6 new duty next period", highs2, 192);
        wr(2'd0, 8'h00);
        @(negedge clk);

        // R4 source select: select strobe 2, others active
        wr(2'd1, 8'h20);
        wr(2'd0, 8'h05);
        @(negedge clk);
        tick = 4'b1011;
        repeat (20) @(negedge clk);
        rd(2'd2, v); check("R4 unselected strobes ignored", v, 0);
        tick = 4'b0100;
        repeat (10) @(negedge clk);
        tick = 4'b0000;
        rd(2'd2, v); check("R4 selected strobe counts", v, 10);
        check("R5 high below latch", int'(pwm), 1);
        wr(2'd0, 8'h00);
        @(negedge clk);

        // R8 R9 interval mode
        wr(2'd1, 8'h05);
        wr(2'd0, 8'h10);
        tick = 4'b0001;
        repeat (5) @(negedge clk);
        check("R8 no irq before match", int'(irq), 0);
        rd(2'd2, v); check("R8 cnt at compare", v, 5);
        @(negedge clk);
        tick = 4'b0000;
        check("R9 irq on match", int'(irq), 1);
        rd(2'd2, v); check("R8 cnt cleared on match", v, 0);
        rd(2'd0, v); check("R8 flag set", v, 8'h18);
        wr(2'd0, 8'h18);
        check("R9 writing 1 keeps flag", int'(irq), 1);
        wr(2'd0, 8'h10);
        check("R9 writing 0 clears flag", int'(irq), 0);
        wr(2'd0, 8'h00);
        tick = 4'b0001;
        repeat (6) @(negedge clk);
        tick = 4'b0000;
        check("R9 irq masked by enable", int'(irq), 0);
        rd(2'd0, v); check("R9 flag set while masked", v, 8'h08);

        // R10 suppression in waveform mode
        wr(2'd0, 8'h19);
        @(negedge clk);
        check("R10 irq low in pwm", int'(irq), 0);
        wr(2'd0, 8'h11);
        tick = 4'b0001;
        repeat (300) @(negedge clk);
        tick = 4'b0000;
        check("R10 irq stays low", int'(irq), 0);
        rd(2'd0, v); check("R10 flag not set in pwm", v, 8'h11);
        wr(2'd0, 8'h00);
        @(negedge clk);

        // R1 reset mid-run
        wr(2'd1, 8'h80);
        wr(2'd0, 8'h01);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1 pin low after reset", int'(pwm), 0);
        rd(2'd1, v); check("R1 cmp cleared", v, 0);

        finish_run();
    end

endmodule